// File: doc/BRIEF.md
# Instruction Pointer with Boot Path Sequencer

This block holds the 16-bit instruction pointer for a word-addressed program store of 65536 sixteen-bit words. Every accepted fetch advances the pointer by one. Software can write a new value into it, and the branch and interrupt logic can load a target into it. The new address is presented as the fetch address on the cycle after the write or load. Software reads the pointer through `fetch_addr`, which always shows the address of the next fetch.

After reset the pointer starts at 8000h, the entry of the boot ROM in the upper half of the code space. A small stub stands in for the boot ROM code. It counts a fixed number of fetches and then looks at a sticky programming-enable flag. If the flag is set, execution stays in loader mode and the pointer keeps running through the ROM. If the flag is clear, the pointer is redirected to the user vector at 0000h. A debug port can set the flag only while reset is held. Loader code can clear it and then request a reset, so that the next boot goes straight to user code.

Top module: `fetch_ptr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `fetch_addr` = 8000h, `fetch_req` = 0 and `boot_path` = 2'b00 (ROM phase). The first edge with `rst` low sets `fetch_req` to 1.
- R2: With no load pending, a cycle with `fetch_strobe` high raises `fetch_addr` by exactly 1 on the next cycle. A cycle without `fetch_strobe` leaves it unchanged.
- R3: An increment from FFFFh gives 0000h.
- R4: `sw_wr_en` high puts `sw_wr_data` on `fetch_addr` in the next cycle. It overrides a simultaneous fetch increment.
- R5: `jmp_en` high puts `jmp_addr` on `fetch_addr` in the next cycle. It wins over a simultaneous software write and over a fetch.
- R6: `prog_enable` takes the value of `dbg_prog_req` on each reset edge. Outside reset, `dbg_prog_req` has no effect on it.
- R7: `prog_clr` high clears `prog_enable` on the next cycle and leaves `boot_path` unchanged. A reset after a clear with no debug request boots to user code.
- R8: In the ROM phase with `prog_enable` = 0, the 4th fetch (parameter `BOOT_FETCHES`) after reset is not incremented. Instead `fetch_addr` becomes 0000h and `boot_path` becomes 2'b10 (user).
- R9: In the ROM phase with `prog_enable` = 1, the 4th fetch increments normally, so `fetch_addr` reaches 8004h, and `boot_path` becomes 2'b01 (loader).
- R10: Once `boot_path` has left 2'b00, it holds its value until the next reset, whatever fetches, writes or loads occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_strobe | input | 1 | A fetch from `fetch_addr` was taken this cycle |
| sw_wr_en | input | 1 | Software write to the pointer |
| sw_wr_data | input | 16 | Value written by software |
| jmp_en | input | 1 | Branch or interrupt load |
| jmp_addr | input | 16 | Branch or interrupt target |
| dbg_prog_req | input | 1 | Debug request to set programming enable, sampled only in reset |
| prog_clr | input | 1 | Loader clears programming enable |
| fetch_addr | output | 16 | Current pointer: address of the next fetch |
| fetch_req | output | 1 | Fetch request, high once out of reset |
| boot_path | output | 2 | 00 ROM phase, 01 loader, 10 user |
| prog_enable | output | 1 | Programming-enable flag |

## Verification
A wrong pointer value is visible on `fetch_addr` one cycle after the offending edge, because the register drives the port directly. A stub counter that is off by one makes the jump to 0000h come one fetch early or late. A wrong decision shows on `boot_path` in the same cycle that the address jumps or fails to jump. A corrupted programming-enable flag appears on `prog_enable` at once. Its effect on the boot choice appears only at the 4th fetch after the next reset.

// File: rtl/fptr_pkg.sv
package fptr_pkg;

    localparam int unsigned ADDR_W = 16;

    typedef logic [ADDR_W-1:0] paddr_t;

    localparam paddr_t ROM_ENTRY = 16'h8000;
    localparam paddr_t USER_VEC  = 16'h0000;

    typedef enum logic [1:0] {
        PATH_ROM    = 2'b00,
        PATH_LOADER = 2'b01,
        PATH_USER   = 2'b10
    } boot_path_e;

    typedef struct packed {
        logic   valid;
        paddr_t addr;
    } ip_load_t;

    // Priority: branch/interrupt load, then software write, then fetch
    // (a boot redirect replaces the increment of that fetch).
    function automatic paddr_t pick_next(
        input paddr_t   cur,
        input logic     fetch,
        input ip_load_t jmp,
        input ip_load_t sw,
        input ip_load_t redir
    );
        paddr_t nxt;
        if (jmp.valid)      nxt = jmp.addr;
        else if (sw.valid)  nxt = sw.addr;
        else if (fetch)     nxt = redir.valid ? redir.addr : cur + paddr_t'(1);
        else                nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/fptr_ip_reg.sv
module fptr_ip_reg
    import fptr_pkg::*;
#(
    parameter paddr_t RESET_ADDR = ROM_ENTRY
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fetch,
    input  ip_load_t jmp_ld,
    input  ip_load_t sw_ld,
    input  ip_load_t redir_ld,
    output paddr_t   ip_q
);

    always_ff @(posedge clk) begin
        if (rst) ip_q <= RESET_ADDR;
        else     ip_q <= pick_next(ip_q, fetch, jmp_ld, sw_ld, redir_ld);
    end

endmodule

// File: rtl/fptr_pen_reg.sv
module fptr_pen_reg (
    input  logic clk,
    input  logic rst,
    input  logic dbg_set,
    input  logic clr,
    output logic pen_q
);

    // The flag is loaded from the debug line only while reset is held.
    always_ff @(posedge clk) begin
        if (rst)      pen_q <= dbg_set;
        else if (clr) pen_q <= 1'b0;
    end

endmodule

// File: rtl/fptr_boot_stub.sv
module fptr_boot_stub
    import fptr_pkg::*;
#(
    parameter int unsigned BOOT_FETCHES = 4,
    parameter paddr_t      USER_ADDR    = USER_VEC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch,
    input  logic       prog_en,
    output ip_load_t   redir_ld,
    output boot_path_e path_q,
    output logic       req_q
);

    localparam int unsigned CW = $clog2(BOOT_FETCHES + 1);
    localparam logic [CW-1:0] LAST = CW'(BOOT_FETCHES - 1);

    logic [CW-1:0] cnt_q;
    logic          decide;

    assign decide = (path_q == PATH_ROM) && fetch && (cnt_q == LAST);

    always_comb begin
        redir_ld.valid = decide && !prog_en;
        redir_ld.addr  = USER_ADDR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= PATH_ROM;
            cnt_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= 1'b1;
            if (decide) begin
                path_q <= prog_en ? PATH_LOADER : PATH_USER;
            end else if (path_q == PATH_ROM && fetch) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/fetch_ptr_unit.sv
module fetch_ptr_unit
    import fptr_pkg::*;
#(
    parameter int unsigned BOOT_FETCHES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_strobe,
    input  logic        sw_wr_en,
    input  logic [15:0] sw_wr_data,
    input  logic        jmp_en,
    input  logic [15:0] jmp_addr,
    input  logic        dbg_prog_req,
    input  logic        prog_clr,
    output logic [15:0] fetch_addr,
    output logic        fetch_req,
    output logic [1:0]  boot_path,
    output logic        prog_enable
);

    ip_load_t   jmp_ld, sw_ld, redir_ld;
    boot_path_e path;
    paddr_t     ip;
    logic       pen;

    always_comb begin
        jmp_ld.valid = jmp_en;
        jmp_ld.addr  = jmp_addr;
        sw_ld.valid  = sw_wr_en;
        sw_ld.addr   = sw_wr_data;
    end

    fptr_pen_reg u_pen (
        .clk     (clk),
        .rst     (rst),
        .dbg_set (dbg_prog_req),
        .clr     (prog_clr),
        .pen_q   (pen)
    );

    fptr_boot_stub #(
        .BOOT_FETCHES (BOOT_FETCHES),
        .USER_ADDR    (USER_VEC)
    ) u_stub (
        .clk      (clk),
        .rst      (rst),
        .fetch    (fetch_strobe),
        .prog_en  (pen),
        .redir_ld (redir_ld),
        .path_q   (path),
        .req_q    (fetch_req)
    );

    fptr_ip_reg #(
        .RESET_ADDR (ROM_ENTRY)
    ) u_ip (
        .clk      (clk),
        .rst      (rst),
        .fetch    (fetch_strobe),
        .jmp_ld   (jmp_ld),
        .sw_ld    (sw_ld),
        .redir_ld (redir_ld),
        .ip_q     (ip)
    );

    assign fetch_addr  = ip;
    assign boot_path   = path;
    assign prog_enable = pen;

endmodule

// File: rtl/fptr_chk.sv
module fptr_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_strobe,
    input logic        sw_wr_en,
    input logic [15:0] sw_wr_data,
    input logic        jmp_en,
    input logic [15:0] jmp_addr,
    input logic        prog_clr,
    input logic [15:0] fetch_addr,
    input logic        fetch_req,
    input logic [1:0]  boot_path,
    input logic        prog_enable
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (fetch_addr == 16'h8000 && !fetch_req && boot_path == 2'b00)); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (fetch_strobe && !sw_wr_en && !jmp_en && boot_path != 2'b00)
        |=> fetch_addr == $past(fetch_addr) + 16'd1); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fetch_strobe && !sw_wr_en && !jmp_en) |=> $stable(fetch_addr)); // R2

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && !jmp_en) |=> fetch_addr == $past(sw_wr_data)); // R4

    AST_JMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        jmp_en |=> fetch_addr == $past(jmp_addr)); // R5

    AST_PEN_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !prog_enable |=> !prog_enable); // R6

    AST_PEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        prog_clr |=> !prog_enable); // R7

    AST_USER_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (boot_path == 2'b10 && $past(boot_path) == 2'b00 && !$past(jmp_en) && !$past(sw_wr_en))
        |-> fetch_addr == 16'h0000); // R8

    AST_LOADER_STAY: assert property (@(posedge clk) disable iff (rst)
        (boot_path == 2'b01 && $past(boot_path) == 2'b00 && !$past(jmp_en) && !$past(sw_wr_en))
        |-> fetch_addr == $past(fetch_addr) + 16'd1); // R9

    AST_PATH_STICKY: assert property (@(posedge clk) disable iff (rst)
        (boot_path != 2'b00) |=> $stable(boot_path)); // R10

endmodule

bind fetch_ptr_unit fptr_chk u_chk (.*);

// File: tb/sim_fetch_ptr_unit.sv
`timescale 1ns/1ps
module sim_fetch_ptr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_strobe = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [15:0] sw_wr_data = '0;
    logic        jmp_en = 1'b0;
    logic [15:0] jmp_addr = '0;
    logic        dbg_prog_req = 1'b0;
    logic        prog_clr = 1'b0;
    logic [15:0] fetch_addr;
    logic        fetch_req;
    logic [1:0]  boot_path;
    logic        prog_enable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_ptr_unit u0 (.*);

    // {fetch, sw_en, sw_data, jmp_en, jmp_addr, expected fetch_addr}
    localparam int NV = 12;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0001},
        {1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0002},
        {1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0002},
        {1'b1, 1'b1, 16'h1234, 1'b0, 16'h0000, 16'h1234},
        {1'b0, 1'b1, 16'h5555, 1'b1, 16'h4000, 16'h4000},
        {1'b1, 1'b0, 16'h0000, 1'b1, 16'hABCD, 16'hABCD},
        {1'b0, 1'b1, 16'hFFFE, 1'b0, 16'h0000, 16'hFFFE},
        {1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'hFFFF},
        {1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0000},
        {1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h0001},
        {1'b0, 1'b1, 16'h0100, 1'b0, 16'h0000, 16'h0100},
        {1'b1, 1'b1, 16'h0777, 1'b1, 16'h0200, 16'h0200}
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // called at a negedge; applies inputs across one posedge, returns at next negedge
    task automatic drive(input logic f, input logic swe, input logic [15:0] swd,
                         input logic je, input logic [15:0] ja);
        fetch_strobe = f; sw_wr_en = swe; sw_wr_data = swd; jmp_en = je; jmp_addr = ja;
        @(negedge clk);
        fetch_strobe = 1'b0; sw_wr_en = 1'b0; jmp_en = 1'b0;
    endtask

    task automatic do_reset(input logic dbg);
        rst = 1'b1; dbg_prog_req = dbg;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "addr in reset", fetch_addr, 16'h8000);
        chk("R1", "req in reset", {15'd0, fetch_req}, 16'd0);
        chk("R1", "path in reset", {14'd0, boot_path}, 16'd0);
        chk("R6", "prog_enable after reset", {15'd0, prog_enable}, {15'd0, dbg});
        rst = 1'b0; dbg_prog_req = 1'b0;
        @(negedge clk);
        chk("R1", "req after reset", {15'd0, fetch_req}, 16'd1);
    endtask

    initial begin
        @(negedge clk);
        // boot with programming disabled
        do_reset(1'b0);
        dbg_prog_req = 1'b1;
        @(negedge clk);
        dbg_prog_req = 1'b0;
        chk("R6", "debug request outside reset", {15'd0, prog_enable}, 16'd0);
        chk("R2", "idle hold", fetch_addr, 16'h8000);
        for (int k = 1; k <= 3; k++) begin
            drive(1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
            chk("R2", "rom fetch", fetch_addr, 16'h8000 + 16'(k));
            chk("R8", "still rom phase", {14'd0, boot_path}, 16'd0);
        end
        drive(1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
        chk("R8", "no strobe no count", {14'd0, boot_path}, 16'd0);
        drive(1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
        chk("R8", "redirect to user vector", fetch_addr, 16'h0000);
        chk("R8", "user path", {14'd0, boot_path}, 16'd2);

        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            string rq;
            v = VEC[i];
            if (v[32])                    rq = "R5";
            else if (v[49])               rq = "R4";
            else if (v[15:0] == 16'h0000) rq = "R3";
            else                          rq = "R2";
            drive(v[50], v[49], v[48:33], v[32], v[31:16]);
            chk(rq, $sformatf("vector %0d", i), fetch_addr, v[15:0]);
            chk("R10", "path held in user", {14'd0, boot_path}, 16'd2);
        end

        // boot with programming enabled
        do_reset(1'b1);
        for (int k = 1; k <= 4; k++) begin
            drive(1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
            chk("R9", "loader fetch", fetch_addr, 16'h8000 + 16'(k));
        end
        chk("R9", "loader path", {14'd0, boot_path}, 16'd1);
        for (int k = 5; k <= 10; k++) begin
            drive(1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
        end
        chk("R10", "loader continues", fetch_addr, 16'h800A);
        chk("R10", "loader path held", {14'd0, boot_path}, 16'd1);
        drive(1'b0, 1'b0, 16'h0, 1'b1, 16'h0000);
        chk("R10", "path after jump to zero", {14'd0, boot_path}, 16'd1);

        prog_clr = 1'b1;
        @(negedge clk);
        prog_clr = 1'b0;
        chk("R7", "flag cleared", {15'd0, prog_enable}, 16'd0);
        chk("R7", "path kept on clear", {14'd0, boot_path}, 16'd1);

        // reboot after clear goes to user
        do_reset(1'b0);
        for (int k = 1; k <= 4; k++) begin
            drive(1'b1, 1'b0, 16'h0, 1'b0, 16'h0);
        end
        chk("R7", "reboot to user addr", fetch_addr, 16'h0000);
        chk("R7", "reboot to user path", {14'd0, boot_path}, 16'd2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule